// File: doc/BRIEF.md
# Byte-Command I2C Master

This block is a single-master I2C controller that a processor drives through four byte-wide registers. Each transaction is broken into single-byte operations. Software loads a byte, then writes one command that transmits or receives that byte. The same command can also place a START condition before the byte and a STOP condition after it. When the byte, and any STOP, is finished, the block raises an interrupt.

If a byte ends without a STOP, the master keeps SCL pulled low. The bus stays stretched until software services the interrupt and writes the next command. The SCL rate comes from a 16-bit divider. Each bit period is made of four quarter phases, and each quarter lasts divider+1 system clocks. SDA and SCL are open-drain: the block only produces pull-low enables, and it reads SDA back.

Register map on `bus_addr`:
- 0: divider low byte.
- 1: divider high byte.
- 2: write loads the transmit byte, read returns the last received byte.
- 3: write issues a command, read returns the status.

Command bits: 7 START, 6 STOP, 5 RD, 4 WR, 3 NACK (1 = master leaves the acknowledge bit high on a read), 0 IACK. Status bits: 7 RXACK, 1 BUSY, 0 IRQ flag, all others 0.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status reads 8'h80 (RXACK=1, BUSY=0, IRQ flag=0), `irq` is 0, and both `scl_oe` and `sda_oe` are 0.
- R2: During a byte, SCL rises once every 4*(D+1) clocks, where D is the 16-bit divider held in registers 0 and 1.
- R3: A command with WR (bit 4) sends the transmit byte MSB first, with SDA changing only while SCL is low. BUSY (status bit 1) reads 1 from the cycle after the command until the byte, and any STOP, has completed.
- R4: START (bit 7) together with WR makes the block produce a START condition before the byte. A command that has START or STOP but neither WR nor RD causes no bus activity and leaves BUSY at 0.
- R5: STOP (bit 6) makes the block produce a STOP condition after the 9th clock of the byte. After that, both SCL and SDA are released.
- R6: Completion sets the IRQ flag (status bit 0) and `irq`. A command written with IACK (bit 0) clears the flag.
- R7: When a byte finishes without STOP, `scl_oe` stays 1 until the next command is accepted.
- R8: A command with RD (bit 5) clocks in 8 bits MSB first and makes them readable at register 2. In the 9th clock the master pulls SDA low when NACK (bit 3) is 0 and releases it when NACK is 1.
- R9: RXACK (status bit 7) takes the SDA level sampled in the 9th clock of a byte the master writes. A byte the master reads leaves RXACK unchanged.
- R10: A WR or RD command written while BUSY is 1 is ignored: no extra byte appears on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from `bus_addr` |
| irq | output | 1 | Byte-complete interrupt, level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong quarter-phase or bit counter shows up within one byte. The bus byte captured on SCL edges would differ from the transmit byte, or the measured SCL period would not match the divider. A wrong sequencer state appears as a START or STOP count that does not match the commands, or as SCL released during the inter-byte hold. Either is visible as soon as the affected byte completes. A misrouted acknowledge is seen at the next status or register-2 read, as a wrong RXACK value or a received byte that differs from what the modelled slave drove.

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master #(
  parameter logic [15:0] DIV_RST = 16'd99
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int DIV_W  = 16;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1) + 1;
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_STOP, S_HOLD} st_t;

  st_t              st;
  logic [DIV_W-1:0] div, cnt;
  logic [1:0]       q;
  logic [CNT_W-1:0] bitn;
  logic [BYTE_W-1:0] sh, txr, rxr;
  logic f_rd, f_sto, f_nack, from_hold, smp, rxack, ifl;

  logic tip, cmd_wr, go, tick, last_q, byte_end, finish;

  assign tip      = (st == S_START) || (st == S_BIT) || (st == S_STOP);
  assign cmd_wr   = bus_we && (bus_addr == 2'd3);
  assign go       = cmd_wr && (bus_wdata[4] || bus_wdata[5]) && !tip;
  assign tick     = (cnt == div);
  assign last_q   = tick && (q == 2'd3);
  assign byte_end = (st == S_BIT) && last_q && (bitn == ACK_SLOT);
  assign finish   = (byte_end && !f_sto) || ((st == S_STOP) && last_q);
  assign irq      = ifl;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = div[7:0];
      2'd1:    bus_rdata = div[15:8];
      2'd2:    bus_rdata = rxr;
      default: bus_rdata = {rxack, 5'd0, tip, ifl};
    endcase
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_HOLD:  scl_oe = 1'b1;
      S_START: begin
        scl_oe = (q == 2'd0) ? from_hold : (q == 2'd3);
        sda_oe = q[1];
      end
      S_BIT: begin
        scl_oe = (q == 2'd0) || (q == 2'd3);
        sda_oe = (bitn == ACK_SLOT) ? (f_rd && !f_nack) : (!f_rd && !sh[BYTE_W-1]);
      end
      S_STOP: begin
        scl_oe = (q == 2'd0);
        sda_oe = (q != 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      div       <= DIV_RST;
      cnt       <= '0;
      q         <= '0;
      bitn      <= '0;
      sh        <= '0;
      txr       <= '0;
      rxr       <= '0;
      f_rd      <= 1'b0;
      f_sto     <= 1'b0;
      f_nack    <= 1'b0;
      from_hold <= 1'b0;
      smp       <= 1'b1;
      rxack     <= 1'b1;
      ifl       <= 1'b0;
    end else begin
      if (bus_we && bus_addr == 2'd0) div[7:0]  <= bus_wdata;
      if (bus_we && bus_addr == 2'd1) div[15:8] <= bus_wdata;
      if (bus_we && bus_addr == 2'd2) txr       <= bus_wdata;

      cnt <= (go || tick) ? '0 : cnt + 1'b1;

      if (finish)                      ifl <= 1'b1;
      else if (cmd_wr && bus_wdata[0]) ifl <= 1'b0;

      if (go) begin
        st        <= bus_wdata[7] ? S_START : S_BIT;
        q         <= '0;
        bitn      <= '0;
        sh        <= txr;
        f_rd      <= !bus_wdata[4];
        f_sto     <= bus_wdata[6];
        f_nack    <= bus_wdata[3];
        from_hold <= (st == S_HOLD);
      end else if (tick && tip) begin
        q <= q + 1'b1;
        if (st == S_BIT && q == 2'd2) begin
          smp <= sda_in;
          if (bitn == ACK_SLOT && !f_rd) rxack <= sda_in;
        end
        if (q == 2'd3) begin
          case (st)
            S_START: st <= S_BIT;
            S_BIT: begin
              if (bitn == ACK_SLOT) begin
                st <= f_sto ? S_STOP : S_HOLD;
                if (f_rd) rxr <= sh;
              end else begin
                bitn <= bitn + 1'b1;
                sh   <= {sh[BYTE_W-2:0], f_rd ? smp : 1'b0};
              end
            end
            S_STOP:  st <= S_IDLE;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_byte_master_chk.sv
`timescale 1ns/1ps
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_req,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [2:0] st,
  input logic       tip,
  input logic       f_rd,
  input logic       rxack
);
  localparam logic [2:0] C_IDLE = 3'd0;
  localparam logic [2:0] C_BIT  = 3'd2;
  localparam logic [2:0] C_HOLD = 3'd4;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE) |-> (!scl_oe && !sda_oe)); // R5
  AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_HOLD) |-> scl_oe); // R7
  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tip) |-> irq); // R6
  AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tip) |-> $past(cmd_req)); // R4
  AST_READ_KEEPS_RXACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tip && f_rd) |=> $stable(rxack)); // R9
  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_BIT && $past(st) == C_BIT && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R3
endmodule

bind i2c_byte_master i2c_byte_master_chk chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .cmd_req(bus_we && bus_addr == 2'd3 && (bus_wdata[4] || bus_wdata[5])),
  .irq(irq),
  .scl_oe(scl_oe),
  .sda_oe(sda_oe),
  .st(st),
  .tip(tip),
  .f_rd(f_rd),
  .rxack(rxack)
);

// File: tb/i2c_byte_master_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic irq, scl_oe, sda_oe;
  logic scl_w, sda_w, slv_drv;

  int total = 0, bad = 0;
  bit finished = 0;

  // slave model and bus monitor state
  int pc = 0, p = 0, starts = 0, stops = 0, nbytes = 0;
  logic scl_q = 1'b1, sda_q = 1'b1;
  logic [7:0] mon_sh = 8'd0, mon_byte = 8'd0;
  logic mon_ack = 1'b1;
  time last_rise = 0, gap = 0;
  logic slv_tx = 1'b0, slv_ack_en = 1'b1;
  logic [7:0] slv_byte = 8'd0;
  int slv_gen = 0, nack_gen = 0;

  always #5 clk = ~clk;

  i2c_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .sda_in(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  function automatic logic slave_pull(input logic tx, input int ph, input logic [7:0] b,
                                      input logic ack_en, input bit act);
    if (tx) return act && ph < 8 && !b[7 - ph];
    return ph == 8 && ack_en;
  endfunction

  assign slv_drv = slave_pull(slv_tx, p, slv_byte, slv_ack_en, slv_gen != nack_gen);
  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | slv_drv);

  always @(scl_w or sda_w) begin
    if (scl_w && !scl_q) begin
      if (pc >= 1 && pc <= 7) gap = $time - last_rise;
      last_rise = $time;
      if (pc < 8) mon_sh = {mon_sh[6:0], sda_w};
      else begin
        mon_ack = sda_w;
        mon_byte = mon_sh;
        nbytes++;
        if (slv_tx && sda_w) nack_gen = slv_gen;
      end
      pc = (pc == 8) ? 0 : pc + 1;
    end else if (!scl_w && scl_q) begin
      p = pc;
    end else if (scl_w && scl_q && sda_q && !sda_w) begin
      pc = 0;
      starts++;
    end else if (scl_w && scl_q && !sda_q && sda_w) begin
      stops++;
    end
    scl_q = scl_w;
    sda_q = sda_w;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic set_div(input int d);
    reg_wr(2'd0, 8'(d));
    reg_wr(2'd1, 8'(d >> 8));
  endtask

  // issue one byte command (with IACK), check busy, wait for completion
  task automatic byte_op(input logic [7:0] cmd);
    logic [7:0] s;
    int n = 0;
    reg_wr(2'd3, cmd | 8'h01);
    reg_rd(2'd3, s);
    chk(s[1] == 1'b1, "R3 busy after command", s[1], 1);
    chk(irq == 1'b0, "R6 iack clears irq", irq, 0);
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    chk(irq == 1'b1, "R6 irq on completion", irq, 1);
    reg_rd(2'd3, s);
    chk(s[1] == 1'b0, "R3 busy clears", s[1], 0);
    chk(s[0] == 1'b1, "R6 flag set", s[0], 1);
  endtask

  task automatic addr_phase(input logic [7:0] a);
    logic [7:0] s;
    int s0 = starts;
    slv_tx = 1'b0; slv_ack_en = 1'b1;
    reg_wr(2'd2, a);
    byte_op(8'h90);
    chk(mon_byte == a, "R3 address byte on bus", mon_byte, a);
    chk(starts == s0 + 1, "R4 start generated", starts, s0 + 1);
    reg_rd(2'd3, s);
    chk(s[7] == 1'b0, "R9 rxack from slave ack", s[7], 0);
    chk(scl_oe == 1'b1, "R7 scl held after byte", scl_oe, 1);
    repeat (15) @(negedge clk);
    chk(scl_oe == 1'b1, "R7 scl still held", scl_oe, 1);
  endtask

  initial begin
    logic [7:0] s, d;
    int dv, nb, e0, s0;
    bit last;
    void'($urandom(32'h5EED_1C2B));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_rd(2'd3, s);
    chk(s == 8'h80, "R1 reset status", s, 8'h80);
    chk(irq == 1'b0 && scl_oe == 1'b0 && sda_oe == 1'b0, "R1 reset outputs",
        {irq, scl_oe, sda_oe}, 0);

    set_div(1);
    // R4: START/STOP alone are ignored
    reg_wr(2'd3, 8'hC0);
    repeat (30) @(negedge clk);
    reg_rd(2'd3, s);
    chk(s[1] == 1'b0, "R4 lone start/stop leaves busy low", s[1], 0);
    chk(starts == 0 && stops == 0 && scl_oe == 1'b0, "R4 no bus activity",
        starts + stops, 0);

    for (int it = 0; it < 8; it++) begin
      dv = $urandom_range(0, 5);
      set_div(dv);
      if ($urandom_range(0, 1) == 0) begin
        addr_phase({7'($urandom), 1'b0});
        nb = $urandom_range(1, 3);
        for (int k = 0; k < nb; k++) begin
          last = (k == nb - 1);
          d = 8'($urandom);
          slv_ack_en = 1'($urandom);
          s0 = stops;
          reg_wr(2'd2, d);
          byte_op(last ? 8'h50 : 8'h10);
          chk(mon_byte == d, "R3 data byte on bus", mon_byte, d);
          if (k == 0) chk(gap == 40 * (dv + 1), "R2 scl period", int'(gap), 40 * (dv + 1));
          reg_rd(2'd3, s);
          chk(s[7] == !slv_ack_en, "R9 rxack follows slave", s[7], !slv_ack_en);
          if (last) begin
            chk(stops == s0 + 1, "R5 stop generated", stops, s0 + 1);
            chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R5 bus released", {scl_oe, sda_oe}, 0);
          end else begin
            chk(scl_oe == 1'b1, "R7 hold between writes", scl_oe, 1);
          end
        end
      end else begin
        addr_phase({7'($urandom), 1'b1});
        nb = $urandom_range(1, 3);
        slv_tx = 1'b1;
        slv_gen++;
        for (int k = 0; k < nb; k++) begin
          last = (k == nb - 1);
          slv_byte = 8'($urandom);
          byte_op(last ? 8'h68 : 8'h20);
          reg_rd(2'd2, d);
          chk(d == slv_byte, "R8 received byte", d, slv_byte);
          chk(mon_ack == last, "R8 master ack level", mon_ack, last);
          reg_rd(2'd3, s);
          chk(s[7] == 1'b0, "R9 read leaves rxack", s[7], 0);
        end
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R5 released after read", {scl_oe, sda_oe}, 0);
        slv_tx = 1'b0;
      end
    end

    // R10: a second command while busy is ignored
    set_div(2);
    slv_tx = 1'b0; slv_ack_en = 1'b1;
    reg_wr(2'd2, 8'hA5);
    e0 = nbytes;
    reg_wr(2'd3, 8'h91);
    reg_wr(2'd2, 8'h3C);
    reg_wr(2'd3, 8'h11);
    s0 = 0;
    while (!irq && s0 < 20000) begin @(negedge clk); s0++; end
    repeat (200) @(negedge clk);
    reg_rd(2'd3, s);
    chk(nbytes == e0 + 1, "R10 one byte only", nbytes - e0, 1);
    chk(mon_byte == 8'hA5, "R10 original byte sent", mon_byte, 8'hA5);
    chk(s[1] == 1'b0, "R10 no late busy", s[1], 0);
    byte_op(8'h50);
    chk(mon_byte == 8'h3C && scl_oe == 1'b0, "R5 closing byte and release", mon_byte, 8'h3C);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule